// File: doc/BRIEF.md
# Paired-Bank Flash Access Front-End

This block sits between a 32-bit processor bus and a pair of 16-bit-wide flash physical blocks. Each block is modelled as a plain register array. Reads can be bytes, aligned halfwords or aligned words. A word joins one halfword from each block. Any access the block cannot serve ends in a bus error response.

Writes never store data directly. An aligned 32-bit write starts the command held in a small command register: program, verify, page erase or mass erase. Software sets that register before the triggering write.

- A program can only pull bits from 1 to 0.
- A page erase restores all-ones to one interleaved page in both blocks at once. The smallest effective erase is two pages of 512 bytes each, so 1 KB.
- A mass erase restores both blocks completely.

Erases step through the array one word pair per clock, under a two-state sequencer:

- State IDLE: serves bus requests. It leaves for ERASE on transition START when an erase command is accepted.
- State ERASE: clears the current word pair on every clock. It returns to IDLE on transition FINISH after the last pair of the range, and pulses the done flag on the same edge.

Top module: `fpair_flash_front`

## Requirements
- R1: The byte address splits as follows, with defaults BLK_HW=1024 and a 4 KB space.
  - Bits [AW-1:2] give the word index.
  - Bit 1 selects the physical block: 0 selects block 0 and returns data bits [15:0]; 1 selects block 1 and returns bits [31:16].
  - Bit 0 selects the byte lane: 0 is the low byte of the halfword, 1 is the high byte.
  - A word read returns {block1, block0}. Byte and halfword results are zero-extended into bus_rdata.
- R2: A request sampled on a clock edge gets exactly one response cycle after that edge: bus_ack for success or bus_err for failure, never both. Without a request, neither is raised.
- R3: The size code is 0 for byte, 1 for halfword, 2 for word and 3 reserved. A read is rejected with bus_err in these cases:
  - a halfword with address bit 0 set;
  - a word with address bits [1:0] not 00;
  - the reserved size.
- R4: A write that is not size 2 at an address with bits [1:0] equal to 00 returns bus_err and leaves the array unchanged.
- R5: An aligned word write while the command register holds 0 (none) returns bus_err and leaves the array unchanged.
- R6: Command code 1 (program) stores old AND data into the addressed word pair. It returns bus_ack, and a 0 bit never returns to 1 through programming.
- R7: Command code 3 (page erase) handles a write inside a 1 KB page pair as follows:
  - It sets all bits of that page pair in both blocks to 1 and leaves other pages unchanged.
  - busy stays high for exactly PAGE_HW clocks, 256 by default.
  - cmd_done pulses for one clock as busy falls.
- R8: Command code 4 (mass erase) sets every bit of both blocks to 1. busy stays high for exactly BLK_HW clocks.
- R9: Command code 2 (verify) returns bus_ack. It raises vfy_ok in the response cycle exactly when the stored word equals bus_wdata, and it leaves the array unchanged.
- R10: Any request sampled while busy is high returns bus_err and has no effect on the array.
- R11: After reset these outputs are low: bus_ack, bus_err, vfy_ok, busy and cmd_done. The command register holds none.
- R12: Command codes 5 to 7 behave as none, so an aligned word write under them returns bus_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load the command register |
| cfg_cmd | input | 3 | Command code to load |
| bus_req | input | 1 | Request valid for one cycle |
| bus_wr | input | 1 | 1 = write (command trigger), 0 = read |
| bus_size | input | 2 | Size code: byte, halfword, word or reserved |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Program mask or verify pattern |
| bus_ack | output | 1 | Successful response |
| bus_err | output | 1 | Transfer error response |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| vfy_ok | output | 1 | Verify match, valid with bus_ack |
| busy | output | 1 | Erase sequence in progress |
| cmd_done | output | 1 | One-cycle pulse when an erase ends |

## Verification
The bench checks every halfword and byte lane against its own model of the two blocks. A swapped block select or byte lane would show up as wrong data on specific address bits.

It applies each misaligned and wrongly sized access, then sweeps the array. An alignment check that is too loose would show either as an ack where an error belongs, or as a silently changed word.

It programs the same word twice to prove that bits only fall. It also probes the bus in the middle of an erase. A design that accepted work while busy would alter words the sweep then reports.

Page erase is run on an inner page. This catches erase ranges that are off by one page or leak into the neighbouring page, and erase counts that stop early or run over.

// File: rtl/fpair_pkg.sv
package fpair_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [2:0] {
        CMD_NONE       = 3'd0,
        CMD_PROGRAM    = 3'd1,
        CMD_VERIFY     = 3'd2,
        CMD_PAGE_ERASE = 3'd3,
        CMD_MASS_ERASE = 3'd4
    } flash_cmd_e;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_READ,
        OP_PROGRAM,
        OP_VERIFY,
        OP_PAGE,
        OP_MASS,
        OP_FAULT
    } bus_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ERASE = 1'b1
    } seq_state_e;

endpackage

// File: rtl/fpair_bank.sv
module fpair_bank #(
    parameter int DEPTH = 1024,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [IW-1:0] rd_idx,
    output logic [15:0]   rd_data,
    input  logic          pgm_en,
    input  logic          er_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [15:0]   pgm_mask
);

    logic [15:0] cells [DEPTH];

    // Erase wins over program; program can only clear bits.
    always_ff @(posedge clk) begin
        if (er_en) begin
            cells[wr_idx] <= '1;
        end else if (pgm_en) begin
            cells[wr_idx] <= cells[wr_idx] & pgm_mask;
        end
        if (rd_en) begin
            rd_data <= cells[rd_idx];
        end
    end

endmodule

// File: rtl/fpair_decode.sv
module fpair_decode
    import fpair_pkg::*;
(
    input  logic        req,
    input  logic        wr,
    input  logic [1:0]  size,
    input  logic [1:0]  addr_lo,
    input  logic [2:0]  cmd,
    input  logic        busy,
    output bus_op_e     op
);

    always_comb begin
        op = OP_IDLE;
        if (req) begin
            if (busy) begin
                op = OP_FAULT;
            end else if (!wr) begin
                unique case (xfer_size_e'(size))
                    SZ_BYTE: op = OP_READ;
                    SZ_HALF: op = addr_lo[0] ? OP_FAULT : OP_READ;
                    SZ_WORD: op = (addr_lo == 2'b00) ? OP_READ : OP_FAULT;
                    default: op = OP_FAULT;
                endcase
            end else if (xfer_size_e'(size) != SZ_WORD || addr_lo != 2'b00) begin
                op = OP_FAULT;
            end else begin
                unique case (cmd)
                    CMD_PROGRAM:    op = OP_PROGRAM;
                    CMD_VERIFY:     op = OP_VERIFY;
                    CMD_PAGE_ERASE: op = OP_PAGE;
                    CMD_MASS_ERASE: op = OP_MASS;
                    default:        op = OP_FAULT;
                endcase
            end
        end
    end

endmodule

// File: rtl/fpair_erase_seq.sv
module fpair_erase_seq
    import fpair_pkg::*;
#(
    parameter int DEPTH   = 1024,
    parameter int PAGE_HW = 256,
    localparam int IW  = $clog2(DEPTH),
    localparam int PGB = $clog2(PAGE_HW),
    localparam int PW  = IW - PGB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_page,
    input  logic          start_mass,
    input  logic [PW-1:0] page_sel,
    output logic          er_en,
    output logic [IW-1:0] er_idx,
    output logic          busy,
    output logic          done
);

    seq_state_e    state_q, state_d;
    logic [IW-1:0] idx_q, end_q;
    logic          done_q;

    // Next-state logic: START from IDLE, FINISH from ERASE.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_page || start_mass) state_d = ST_ERASE;
            ST_ERASE: if (idx_q == end_q)           state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            end_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_ERASE) && (state_d == ST_IDLE);
            if (state_q == ST_IDLE && start_page) begin
                idx_q <= {page_sel, {PGB{1'b0}}};
                end_q <= {page_sel, {PGB{1'b1}}};
            end else if (state_q == ST_IDLE && start_mass) begin
                idx_q <= '0;
                end_q <= '1;
            end else if (state_q == ST_ERASE) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        er_en  = (state_q == ST_ERASE);
        busy   = (state_q == ST_ERASE);
        er_idx = idx_q;
        done   = done_q;
    end

endmodule

// File: rtl/fpair_flash_front.sv
module fpair_flash_front
    import fpair_pkg::*;
#(
    parameter int BLK_HW        = 1024,
    parameter int ROW_BYTES     = 64,
    parameter int ROWS_PER_PAGE = 8,
    localparam int PAGE_HW = ROW_BYTES * ROWS_PER_PAGE / 2,
    localparam int IW      = $clog2(BLK_HW),
    localparam int AW      = IW + 2,
    localparam int PGB     = $clog2(PAGE_HW),
    localparam int PW      = IW - PGB
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_cmd,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic [1:0]    bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic          bus_ack,
    output logic          bus_err,
    output logic [31:0]   bus_rdata,
    output logic          vfy_ok,
    output logic          busy,
    output logic          cmd_done
);

    logic [2:0]    cmd_q;
    bus_op_e       op;
    logic          er_en;
    logic [IW-1:0] er_idx;
    logic [IW-1:0] word_idx;
    logic [IW-1:0] wr_idx;
    logic [15:0]   rd_half [2];

    logic          ack_q, err_q, rd_q, vfy_q;
    logic [1:0]    size_q, lane_q;
    logic [31:0]   cmp_q;

    assign word_idx = bus_addr[AW-1:2];
    assign wr_idx   = er_en ? er_idx : word_idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= CMD_NONE;
        else if (cfg_we) cmd_q <= cfg_cmd;
    end

    fpair_decode u_decode (
        .req     (bus_req),
        .wr      (bus_wr),
        .size    (bus_size),
        .addr_lo (bus_addr[1:0]),
        .cmd     (cmd_q),
        .busy    (busy),
        .op      (op)
    );

    fpair_erase_seq #(.DEPTH(BLK_HW), .PAGE_HW(PAGE_HW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_page (op == OP_PAGE),
        .start_mass (op == OP_MASS),
        .page_sel   (bus_addr[AW-1:PGB+2]),
        .er_en      (er_en),
        .er_idx     (er_idx),
        .busy       (busy),
        .done       (cmd_done)
    );

    for (genvar g = 0; g < 2; g++) begin : g_bank
        fpair_bank #(.DEPTH(BLK_HW)) u_bank (
            .clk      (clk),
            .rd_en    (op == OP_READ || op == OP_VERIFY),
            .rd_idx   (word_idx),
            .rd_data  (rd_half[g]),
            .pgm_en   (op == OP_PROGRAM),
            .er_en    (er_en),
            .wr_idx   (wr_idx),
            .pgm_mask (bus_wdata[16*g +: 16])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q  <= 1'b0;
            err_q  <= 1'b0;
            rd_q   <= 1'b0;
            vfy_q  <= 1'b0;
            size_q <= 2'd0;
            lane_q <= 2'd0;
            cmp_q  <= '0;
        end else begin
            ack_q  <= (op != OP_IDLE) && (op != OP_FAULT);
            err_q  <= (op == OP_FAULT);
            rd_q   <= (op == OP_READ) || (op == OP_VERIFY);
            vfy_q  <= (op == OP_VERIFY);
            size_q <= bus_size;
            lane_q <= bus_addr[1:0];
            cmp_q  <= bus_wdata;
        end
    end

    logic [31:0] word_v;
    logic [15:0] half_v;
    logic [7:0]  byte_v;
    logic [31:0] sel_v;

    always_comb begin
        word_v = {rd_half[1], rd_half[0]};
        half_v = lane_q[1] ? rd_half[1] : rd_half[0];
        byte_v = lane_q[0] ? half_v[15:8] : half_v[7:0];
        unique case (xfer_size_e'(size_q))
            SZ_BYTE: sel_v = {24'd0, byte_v};
            SZ_HALF: sel_v = {16'd0, half_v};
            default: sel_v = word_v;
        endcase
        bus_ack   = ack_q;
        bus_err   = err_q;
        bus_rdata = (ack_q && rd_q) ? sel_v : 32'd0;
        vfy_ok    = ack_q && vfy_q && (word_v == cmp_q);
    end

endmodule

// File: rtl/fpair_flash_front_chk.sv
module fpair_flash_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_req,
    input logic       bus_wr,
    input logic [1:0] bus_size,
    input logic [1:0] bus_addr_lo,
    input logic       bus_ack,
    input logic       bus_err,
    input logic       busy,
    input logic       cmd_done
);

    p_excl_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_ack, bus_err}));

    p_req_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> (bus_ack || bus_err));

    p_no_req_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !(bus_ack || bus_err));

    p_misalign_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && ((bus_size == 2'd1 && bus_addr_lo[0]) ||
         (bus_size == 2'd2 && bus_addr_lo != 2'b00) || bus_size == 2'd3))
        |=> bus_err);

    p_bad_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && (bus_size != 2'd2 || bus_addr_lo != 2'b00))
        |=> bus_err);

    p_busy_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && busy) |=> bus_err);

    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> (!busy && $past(busy)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);

endmodule

bind fpair_flash_front fpair_flash_front_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req     (bus_req),
    .bus_wr      (bus_wr),
    .bus_size    (bus_size),
    .bus_addr_lo (bus_addr[1:0]),
    .bus_ack     (bus_ack),
    .bus_err     (bus_err),
    .busy        (busy),
    .cmd_done    (cmd_done)
);

// File: tb/fpair_flash_front_bench.sv
module fpair_flash_front_bench;

    localparam int NW = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_cmd = 3'd0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_size = 2'd0;
    logic [11:0] bus_addr = 12'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic        bus_ack, bus_err, vfy_ok, busy, cmd_done;
    logic [31:0] bus_rdata;

    int n_vec = 0;
    int n_bad = 0;
    int busy_cnt = 0;
    logic [31:0] model [NW];

    bit          q_err  [$];
    logic [31:0] q_data [$];
    bit          q_cdat [$];
    bit          q_cvfy [$];
    bit          q_evfy [$];
    string       q_tag  [$];

    always #10 clk = ~clk;

    fpair_flash_front u_fpair_flash_front (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_cmd(cfg_cmd),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .vfy_ok(vfy_ok),
        .busy(busy), .cmd_done(cmd_done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expected item per response cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (bus_ack || bus_err) begin
                if (q_err.size() == 0) begin
                    chk(1'b0, "R2 unexpected response", {bus_ack, bus_err}, 0);
                end else begin
                    automatic bit          e  = q_err.pop_front();
                    automatic logic [31:0] d  = q_data.pop_front();
                    automatic bit          cd = q_cdat.pop_front();
                    automatic bit          cv = q_cvfy.pop_front();
                    automatic bit          ev = q_evfy.pop_front();
                    automatic string       t  = q_tag.pop_front();
                    chk(bus_err == e && bus_ack == !e, {t, " response kind"},
                        {bus_ack, bus_err}, {!e, e});
                    if (cd && !e) chk(bus_rdata == d, {t, " data"}, bus_rdata, d);
                    if (cv && !e) chk(vfy_ok == ev, {t, " vfy_ok"}, vfy_ok, ev);
                end
            end
        end
    end

    task automatic issue(input bit wr, input logic [1:0] sz, input logic [11:0] a,
                         input logic [31:0] d, input bit e_err, input logic [31:0] e_data,
                         input bit c_dat, input bit c_vfy, input bit e_vfy, input string tag);
        @(negedge clk);
        q_err.push_back(e_err);
        q_data.push_back(e_data);
        q_cdat.push_back(c_dat);
        q_cvfy.push_back(c_vfy);
        q_evfy.push_back(e_vfy);
        q_tag.push_back(tag);
        bus_req = 1'b1; bus_wr = wr; bus_size = sz; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic set_cmd(input logic [2:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_cmd = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [11:0] a);
        logic [31:0] w;
        logic [15:0] h;
        w = model[a[11:2]];
        h = a[1] ? w[31:16] : w[15:0];
        if (sz == 2'd0) return {24'd0, a[0] ? h[15:8] : h[7:0]};
        if (sz == 2'd1) return {16'd0, h};
        return w;
    endfunction

    task automatic sweep(input string tag);
        for (int i = 0; i < NW; i++)
            issue(1'b0, 2'd2, 12'(i * 4), 32'd0, 1'b0, model[i], 1'b1, 1'b0, 1'b0, tag);
    endtask

    task automatic run_erase(input logic [2:0] c, input logic [11:0] a, input int exp_cyc,
                             input bit probe, input string tag);
        set_cmd(c);
        @(negedge clk);
        busy_cnt = 0;
        issue(1'b1, 2'd2, a, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0, {tag, " start"});
        if (probe) begin
            // R10: requests during an erase are rejected and change nothing
            issue(1'b0, 2'd2, 12'h010, 32'd0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0, "R10 read busy");
            issue(1'b1, 2'd2, 12'h020, 32'h0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0, "R10 write busy");
        end
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (cmd_done) break;
        end
        chk(cmd_done == 1'b1, {tag, " done pulse"}, cmd_done, 1);
        chk(busy_cnt == exp_cyc, {tag, " busy cycles"}, busy_cnt, exp_cyc);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({bus_ack, bus_err, vfy_ok, busy, cmd_done} == 5'd0, "R11 reset outputs",
            {bus_ack, bus_err, vfy_ok, busy, cmd_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R11: command register resets to none, so a trigger is rejected
        issue(1'b1, 2'd2, 12'h000, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R11 cmd none after reset");

        // R8 mass erase
        run_erase(3'd4, 12'h000, NW, 1'b0, "R8 mass");
        for (int i = 0; i < NW; i++) model[i] = 32'hFFFF_FFFF;
        sweep("R8 all ones");

        // R6 program, R1 lanes
        set_cmd(3'd1);
        issue(1'b1, 2'd2, 12'h010, 32'h1234_5678, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 program");
        model[4] = 32'h1234_5678;
        issue(1'b0, 2'd2, 12'h010, 0, 1'b0, 32'h1234_5678, 1'b1, 1'b0, 1'b0, "R1 word");
        issue(1'b0, 2'd1, 12'h010, 0, 1'b0, 32'h5678, 1'b1, 1'b0, 1'b0, "R1 half blk0");
        issue(1'b0, 2'd1, 12'h012, 0, 1'b0, 32'h1234, 1'b1, 1'b0, 1'b0, "R1 half blk1");
        issue(1'b0, 2'd0, 12'h011, 0, 1'b0, 32'h56, 1'b1, 1'b0, 1'b0, "R1 byte hi blk0");
        issue(1'b0, 2'd0, 12'h013, 0, 1'b0, 32'h12, 1'b1, 1'b0, 1'b0, "R1 byte hi blk1");
        issue(1'b0, 2'd0, 12'h012, 0, 1'b0, 32'h34, 1'b1, 1'b0, 1'b0, "R1 byte lo blk1");
        issue(1'b1, 2'd2, 12'h010, 32'hFFFF_0F0F, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 reprogram");
        model[4] = 32'h1234_0608;
        issue(1'b0, 2'd2, 12'h010, 0, 1'b0, 32'h1234_0608, 1'b1, 1'b0, 1'b0, "R6 bits only fall");

        // R3 misaligned reads
        issue(1'b0, 2'd1, 12'h011, 0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R3 half odd");
        issue(1'b0, 2'd2, 12'h012, 0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R3 word off2");
        issue(1'b0, 2'd2, 12'h011, 0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R3 word off1");
        issue(1'b0, 2'd3, 12'h010, 0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R3 reserved size");

        // R4 bad writes with program selected
        issue(1'b1, 2'd0, 12'h010, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R4 byte write");
        issue(1'b1, 2'd1, 12'h010, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R4 half write");
        issue(1'b1, 2'd2, 12'h014 + 12'd2, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R4 word misaligned");
        issue(1'b1, 2'd3, 12'h010, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R4 reserved size");
        issue(1'b0, 2'd2, 12'h010, 0, 1'b0, model[4], 1'b1, 1'b0, 1'b0, "R4 unchanged");
        issue(1'b0, 2'd2, 12'h014, 0, 1'b0, model[5], 1'b1, 1'b0, 1'b0, "R4 unchanged next");

        // R5 / R12 no command selected
        set_cmd(3'd0);
        issue(1'b1, 2'd2, 12'h010, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R5 none");
        set_cmd(3'd6);
        issue(1'b1, 2'd2, 12'h010, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R12 code 6");
        set_cmd(3'd5);
        issue(1'b1, 2'd2, 12'h010, 32'h0, 1'b1, 0, 1'b0, 1'b0, 1'b0, "R12 code 5");
        issue(1'b0, 2'd2, 12'h010, 0, 1'b0, model[4], 1'b1, 1'b0, 1'b0, "R5 unchanged");

        // R9 verify
        set_cmd(3'd2);
        issue(1'b1, 2'd2, 12'h010, 32'h1234_0608, 1'b0, 0, 1'b0, 1'b1, 1'b1, "R9 match");
        issue(1'b1, 2'd2, 12'h010, 32'h1234_0609, 1'b0, 0, 1'b0, 1'b1, 1'b0, "R9 mismatch");
        issue(1'b1, 2'd2, 12'h014, 32'hFFFF_FFFF, 1'b0, 0, 1'b0, 1'b1, 1'b1, "R9 erased match");
        issue(1'b0, 2'd2, 12'h010, 0, 1'b0, model[4], 1'b1, 1'b0, 1'b0, "R9 unchanged");

        // R6 random programs, R1 random narrow reads
        set_cmd(3'd1);
        for (int n = 0; n < 60; n++) begin
            automatic int          wi = int'($urandom % NW);
            automatic logic [31:0] d  = $urandom;
            issue(1'b1, 2'd2, 12'(wi * 4), d, 1'b0, 0, 1'b0, 1'b0, 1'b0, "R6 random program");
            model[wi] = model[wi] & d;
        end
        for (int n = 0; n < 60; n++) begin
            automatic logic [11:0] a  = 12'($urandom);
            automatic logic [1:0]  sz = (n % 2 == 0) ? 2'd0 : 2'd1;
            if (sz == 2'd1) a[0] = 1'b0;
            issue(1'b0, sz, a, 0, 1'b0, exp_rd(sz, a), 1'b1, 1'b0, 1'b0, "R1 random narrow");
        end

        // R7 page erase on page pair 1, with R10 probes
        run_erase(3'd3, 12'h424, NW / 4, 1'b1, "R7 page");
        for (int i = NW / 4; i < NW / 2; i++) model[i] = 32'hFFFF_FFFF;
        sweep("R7 page range");

        // R8 second mass erase
        run_erase(3'd4, 12'hFFC, NW, 1'b0, "R8 mass again");
        for (int i = 0; i < NW; i++) model[i] = 32'hFFFF_FFFF;
        sweep("R8 all ones again");

        repeat (3) @(negedge clk);
        chk(q_err.size() == 0, "R2 missing responses", q_err.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule